// File: doc/BRIEF.md
# NOR Flash Command and Status Controller

This block holds the control logic of a small parallel NOR flash array together with the array itself, held as an on-chip register array. It is clocked synchronously. A host drives active-low chip-enable, write-enable and output-enable strobes, an address and a data bus. Multi-cycle command sequences are decoded into program, sector erase, chip erase, erase suspend, erase resume and return-to-read operations. The array is split into nineteen sectors of scaled-down size, and a boot-position input places the small sectors at the low or the high end of the address space. Each sector can be protected by its own input bit.

A program or erase runs for a fixed number of clock cycles set by parameters. While it runs, the ready/busy output is low. A read during that time returns embedded-algorithm status instead of array contents: a polling bit, a toggle bit and an erase-sector indicator. An erase can be suspended, so that sectors outside the erase can be read or programmed, and then resumed. Driving the hardware reset low abandons any operation and returns to read mode.

The array holds 128 units of `UNIT_W` words. The sectors span 2, 1, 1, 4 and then fifteen times 8 units, counted from the boot end.

Top module: `nor_flash_ctrl`

## Requirements
- R1: A bus write is taken on the clock where chip-enable and write-enable first both sit low with output-enable high. A write-enable pulse made while output-enable is low changes no command state.
- R2: The sequence 0xAA at key address 0x555, then 0x55 at 0x2AA, then 0xA0 at 0x555, then a data write programs that location. The stored word becomes the old word ANDed with the data.
- R3: With `boot_top` low, sector 0 covers units 0..1, sector 1 covers unit 2, sector 2 covers unit 3, sector 3 covers units 4..7, and sectors 4..18 cover 8 units each. With `boot_top` high, the map is mirrored from the top of the array.
- R4: The unlock pair, then 0x80 at 0x555, then the unlock pair again, then 0x30 at any address of a sector erases that sector to 0xFFFF and leaves every other sector unchanged. Using 0x10 at 0x555 in place of 0x30 erases every unprotected sector.
- R5: Program and sector erase aimed at a sector whose `prot` bit is set are ignored: `ry_by` stays high and the data is kept. Chip erase keeps protected sectors.
- R6: A read while a program is busy returns the complement of the programmed data's bit 7 on bit 7. During an erase, bit 7 reads 0. In suspend, a read of an erasing sector returns bit 7 as 1. After completion, reads return the stored data.
- R7: Bit 6 of successive reads inverts while a program or erase is busy, and it stops inverting once the operation ends.
- R8: During an erase, bit 2 inverts on successive reads of a sector being erased and holds steady on reads of other sectors. In suspend, it still inverts on reads of the erasing sector.
- R9: Writing 0xB0 during an erase suspends it, and `ry_by` goes high. A read of a non-erasing sector returns array data. A program to a non-erasing sector runs and completes. A program to an erasing sector is ignored. Writing 0x30 resumes the erase, which then finishes. If 0xB0 lands on the erase's final clock, the erase completes and the controller is in read mode.
- R10: Reset holds `ry_by` high and `dq_oe` low. A reset pulse during a program abandons it without changing the location. Finished operations return to read mode by themselves.
- R11: A cycle that breaks a command sequence (wrong data or wrong key address, 0xF0 included) returns to read mode and starts nothing.
- R12: With `word_mode` low, byte access is used. Command keys are taken from address bits 11:1 (so 0xAAA and 0x555 are used). Byte address bit 0 selects the high byte when 1. Reads return the byte on bits 7:0 with bits 15:8 zero.
- R13: `ry_by` stays low for `PROG_CYC` clocks for a program, counted from the clock that accepts the data write. An erase keeps it low for `ERASE_CYC` clocks per erased sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| word_mode | input | 1 | 1 = word access, 0 = byte access |
| boot_top | input | 1 | 1 = small sectors at the high end |
| prot | input | 19 | Per-sector protect bits |
| addr | input | ADDR_W | Word or byte address |
| dq_in | input | 16 | Write data |
| dq_out | output | 16 | Read data or status, registered at the start of a read |
| dq_oe | output | 1 | Read data valid / bus drive |
| ry_by | output | 1 | High when ready, low while an operation runs |

## Verification
The sharp coincidence comes when an erase-suspend write reaches the clock on which the erase counter expires. Completion and suspension then compete for the same state update. The bench times a 0xB0 write to land exactly on the final erase clock. It then requires `ry_by` to stay high and a read of that sector to return 0xFFFF rather than suspend status. A second overlap, a program issued while an erase is suspended, is judged by checking that the erase countdown resumes intact afterwards.

// File: rtl/nor_flash_ctrl.sv
module nor_flash_ctrl #(
  parameter int UNIT_W    = 2,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 64,
  parameter int ADDR_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              word_mode,
  input  logic              boot_top,
  input  logic [18:0]       prot,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dq_in,
  output logic [15:0]       dq_out,
  output logic              dq_oe,
  output logic              ry_by
);
  localparam int NSEC  = 19;
  localparam int DEPTH = 128 * UNIT_W;
  localparam int WAW   = $clog2(DEPTH);
  localparam int ECW   = $clog2(ERASE_CYC * NSEC + 1);
  localparam int PCW   = $clog2(PROG_CYC + 1);

  typedef enum logic [2:0] {S_RD, S_PROG, S_ERASE, S_SUSP, S_SPROG} st_t;

  function automatic logic [4:0] sec_of(input logic [WAW-1:0] wa, input logic top);
    logic [6:0] u;
    logic [4:0] s;
    u = 7'(wa / UNIT_W);
    if (top) u = 7'd127 - u;
    if (u < 7'd2)      s = 5'd0;
    else if (u < 7'd3) s = 5'd1;
    else if (u < 7'd4) s = 5'd2;
    else if (u < 7'd8) s = 5'd3;
    else               s = 5'(3 + u / 8);
    return top ? 5'd18 - s : s;
  endfunction

  st_t              state;
  logic [2:0]       seq;
  logic [PCW-1:0]   pcnt;
  logic [ECW-1:0]   ecnt;
  logic [NSEC-1:0]  emask;
  logic [WAW-1:0]   pa;
  logic [15:0]      pd;
  logic             pol, t6, t2, wr_q, rd_q;
  logic [15:0]      mem [DEPTH];

  wire wr_now = !ce_n && !we_n && oe_n;
  wire rd_now = !ce_n && !oe_n;
  wire wr_go  = wr_now && !wr_q;
  wire rd_go  = rd_now && !rd_q;
  wire [10:0]    key  = word_mode ? addr[10:0] : addr[11:1];
  wire [WAW-1:0] wa   = word_mode ? addr[WAW-1:0] : addr[WAW:1];
  wire [7:0]     cd   = dq_in[7:0];
  wire [4:0]     wsec = sec_of(wa, boot_top);
  wire at555 = key == 11'h555;
  wire at2aa = key == 11'h2AA;
  wire [15:0] wdata = word_mode ? dq_in :
                      (addr[0] ? {dq_in[7:0], 8'hFF} : {8'hFF, dq_in[7:0]});
  wire [15:0] rdw   = mem[wa];
  wire [15:0] rbyte = word_mode ? rdw : {8'h00, addr[0] ? rdw[15:8] : rdw[7:0]};
  wire prog_ok    = !prot[wsec] && !(state == S_SUSP && emask[wsec]);
  wire prog_busy  = state == S_PROG || state == S_SPROG;
  wire prog_done  = prog_busy && pcnt == PCW'(1);
  wire erase_done = state == S_ERASE && ecnt == ECW'(1);

  assign ry_by = state == S_RD || state == S_SUSP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_RD;  seq <= '0;  pcnt <= '0;  ecnt <= '0;  emask <= '0;
      pa <= '0;  pd <= '1;  pol <= 1'b0;  t6 <= 1'b0;  t2 <= 1'b0;
      wr_q <= 1'b0;  rd_q <= 1'b0;  dq_out <= '0;  dq_oe <= 1'b0;
    end else begin
      wr_q  <= wr_now;
      rd_q  <= rd_now;
      dq_oe <= rd_now;
      if (prog_busy) pcnt <= pcnt - PCW'(1);
      if (state == S_ERASE) ecnt <= ecnt - ECW'(1);
      case (state)
        S_PROG:  if (pcnt == PCW'(1)) state <= S_RD;
        S_SPROG: if (pcnt == PCW'(1)) state <= S_SUSP;
        S_ERASE: begin
          if (ecnt == ECW'(1)) begin
            state <= S_RD;
            emask <= '0;
          end else if (wr_go && cd == 8'hB0) state <= S_SUSP;
        end
        default: if (wr_go) begin
          seq <= 3'd0;
          if (state == S_SUSP && seq == 3'd0 && cd == 8'h30) state <= S_ERASE;
          else case (seq)
            3'd0, 3'd4: if (cd == 8'hAA && at555) seq <= seq + 3'd1;
            3'd1, 3'd5: if (cd == 8'h55 && at2aa) seq <= seq + 3'd1;
            3'd2: begin
              if (cd == 8'hA0 && at555) seq <= 3'd3;
              else if (cd == 8'h80 && at555 && state == S_RD) seq <= 3'd4;
            end
            3'd3: if (prog_ok) begin
              state <= (state == S_RD) ? S_PROG : S_SPROG;
              pcnt  <= PCW'(PROG_CYC);
              pa    <= wa;
              pd    <= wdata;
              pol   <= ~dq_in[7];
            end
            3'd6: begin
              if (cd == 8'h30 && !prot[wsec]) begin
                emask <= NSEC'(1) << wsec;
                ecnt  <= ECW'(ERASE_CYC);
                state <= S_ERASE;
              end else if (cd == 8'h10 && at555 && ~prot != '0) begin
                emask <= ~prot;
                ecnt  <= ECW'(ERASE_CYC * $countones(~prot));
                state <= S_ERASE;
              end
            end
            default: seq <= 3'd0;
          endcase
        end
      endcase
      if (rd_go) begin
        if (prog_busy) begin
          dq_out <= {8'h00, pol, t6, 3'b000, t2, 2'b00};
          t6 <= ~t6;
        end else if (state == S_ERASE) begin
          dq_out <= {8'h00, 1'b0, t6, 3'b000, t2, 2'b00};
          t6 <= ~t6;
          if (emask[wsec]) t2 <= ~t2;
        end else if (state == S_SUSP && emask[wsec]) begin
          dq_out <= {8'h00, 1'b1, t6, 3'b000, t2, 2'b00};
          t2 <= ~t2;
        end else dq_out <= rbyte;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (prog_done) mem[pa] <= mem[pa] & pd;
    if (erase_done)
      for (int i = 0; i < DEPTH; i++)
        if (emask[sec_of(WAW'(i), boot_top)]) mem[WAW'(i)] <= 16'hFFFF;
  end

  assert_oe_blocks_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RD && !oe_n) |=> seq == $past(seq));
  assert_prog_window_R13: assert property (@(posedge clk) disable iff (!rst_n)
    prog_busy |-> (pcnt >= PCW'(1) && pcnt <= PCW'(PROG_CYC)));
  assert_protect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RD && wr_go && seq == 3'd3 && prot[wsec]) |=> ry_by);
  assert_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && prog_busy) |=> t6 != $past(t6));
  assert_suspend_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SUSP || state == S_SPROG) |=> $stable(ecnt));
  assert_auto_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> ry_by);
endmodule

// File: tb/nor_flash_ctrl_bench.sv
module nor_flash_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int PC = 8;
  localparam int EC = 64;

  logic clk = 0, rst_n = 0, ce_n = 1, we_n = 1, oe_n = 1, word_mode = 1, boot_top = 0;
  logic [18:0] prot = '0;
  logic [11:0] addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic dq_oe, ry_by;
  logic [15:0] m [256];
  int errors = 0, checks = 0;
  bit finished = 0;

  nor_flash_ctrl #(.UNIT_W(2), .PROG_CYC(PC), .ERASE_CYC(EC), .ADDR_W(12)) u_nor_flash_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .word_mode(word_mode),
    .boot_top(boot_top), .prot(prot), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .ry_by(ry_by));

  always #(CLK_P/2) clk = ~clk;

  function automatic int size_b(int s);
    if (s == 0) return 2;
    if (s < 3) return 1;
    if (s == 3) return 4;
    return 8;
  endfunction

  function automatic int sec_m(int wa, bit top);
    int u = wa / 2, acc = 0;
    for (int s = 0; s < 19; s++) begin
      acc += top ? size_b(18 - s) : size_b(s);
      if (u < acc) return s;
    end
    return 18;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    addr = 12'(a); dq_in = 16'(d); ce_n = 0; we_n = 0;
    @(negedge clk); we_n = 1; ce_n = 1;
    @(negedge clk);
  endtask

  task automatic rd(int a, output logic [15:0] d);
    addr = 12'(a); ce_n = 0; oe_n = 0;
    @(negedge clk); d = dq_out; oe_n = 1; ce_n = 1;
    @(negedge clk);
  endtask

  task automatic unlock();
    wr(word_mode ? 'h555 : 'hAAA, 'hAA);
    wr(word_mode ? 'h2AA : 'h555, 'h55);
  endtask

  task automatic prog(int a, int d);
    unlock(); wr(word_mode ? 'h555 : 'hAAA, 'hA0); wr(a, d);
  endtask

  task automatic erase_sec(int a);
    unlock(); wr('h555, 'h80); unlock(); wr(a, 'h30);
  endtask

  task automatic wait_ready(output int k);
    k = 1;
    while (!ry_by && k < 100000) begin @(negedge clk); k++; end
  endtask

  task automatic model_erase(logic [18:0] msk);
    for (int i = 0; i < 256; i++) if (msk[sec_m(i, boot_top)]) m[i] = 16'hFFFF;
  endtask

  task automatic rd_chk(int a, string req);
    logic [15:0] d;
    rd(a, d);
    chk(d === m[a], req, d, m[a]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] r1, r2;
    int k;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    chk(ry_by == 1 && dq_oe == 0, "R10 reset state", {ry_by, dq_oe}, 2);
    rst_n = 1;
    @(negedge clk);

    // R4 R13 chip erase of a fresh array
    unlock(); wr('h555, 'h80); unlock(); wr('h555, 'h10);
    wait_ready(k);
    chk(k == EC * 19, "R13 chip erase busy", k, EC * 19);
    model_erase('1);
    rd_chk(0, "R4 chip erase low"); rd_chk(255, "R4 chip erase high");

    // R2 R13 program and AND behaviour
    prog('h20, 'h1234); wait_ready(k);
    chk(k == PC, "R13 program busy", k, PC);
    m['h20] &= 16'h1234; rd_chk('h20, "R2 program");
    prog('h20, 'hF0F0); wait_ready(k);
    m['h20] &= 16'hF0F0; rd_chk('h20, "R2 AND");

    // R6 R7 status during program
    prog('h30, 'h0055);
    rd('h30, r1); rd('h30, r2);
    chk(r1[7] == 1, "R6 DQ7 complement of 0", r1[7], 1);
    chk(r1[6] != r2[6], "R7 DQ6 toggles", r2[6], !r1[6]);
    wait_ready(k); m['h30] &= 16'h0055;
    rd('h30, r1); rd('h30, r2);
    chk(r1 == 16'h0055 && r1 == r2, "R6 R7 true data after end", r2, 16'h0055);
    prog('h31, 'h0080); rd('h31, r1);
    chk(r1[7] == 0, "R6 DQ7 complement of 1", r1[7], 0);
    wait_ready(k); m['h31] &= 16'h0080;

    // R8 R6 status during sector erase (sector of word 0x40)
    prog('h40, 'h0000); wait_ready(k); m['h40] = 0;
    erase_sec('h40);
    rd('h40, r1); rd('h40, r2);
    chk(r1[2] != r2[2], "R8 DQ2 toggles in erasing sector", r2[2], !r1[2]);
    chk(r1[7] == 0 && r2[7] == 0, "R6 DQ7 during erase", r1[7], 0);
    rd('h00, r1); rd('h00, r2);
    chk(r1[2] == r2[2], "R8 DQ2 steady elsewhere", r2[2], r1[2]);
    wait_ready(k);
    model_erase(19'(1) << sec_m('h40, 0));
    rd_chk('h40, "R4 erased sector"); rd_chk('h20, "R4 other sector kept");

    // R3 boot position
    prog(3, 0); wait_ready(k); prog(4, 0); wait_ready(k); prog(6, 0); wait_ready(k);
    m[3] = 0; m[4] = 0; m[6] = 0;
    erase_sec(4); wait_ready(k); m[4] = 16'hFFFF; m[5] = 16'hFFFF;
    rd_chk(3, "R3 bottom boot sector 0"); rd_chk(4, "R3 bottom boot sector 1");
    rd_chk(6, "R3 bottom boot sector 2");
    boot_top = 1;
    prog(251, 0); wait_ready(k); prog(252, 0); wait_ready(k);
    m[251] = 0; m[252] = 0;
    erase_sec(253); wait_ready(k);
    for (int i = 252; i < 256; i++) m[i] = 16'hFFFF;
    rd_chk(252, "R3 top boot sector 18"); rd_chk(251, "R3 top boot sector 17 kept");
    boot_top = 0;

    // R5 protection
    prot = 19'(1) << sec_m('h20, 0);
    prog('h20, 0);
    chk(ry_by == 1, "R5 program on protected", ry_by, 1);
    wait_ready(k); rd_chk('h20, "R5 protected data kept");
    erase_sec('h20);
    chk(ry_by == 1, "R5 erase on protected", ry_by, 1);
    unlock(); wr('h555, 'h80); unlock(); wr('h555, 'h10);
    wait_ready(k);
    chk(k == EC * 18, "R13 chip erase skips protected", k, EC * 18);
    model_erase(~prot);
    rd_chk('h20, "R5 chip erase keeps protected"); rd_chk('h30, "R4 chip erase other");
    prot = '0;

    // R11 broken sequences
    wr('h555, 'hAA); wr('h123, 'h55); wr('h555, 'hA0); wr('h50, 0);
    chk(ry_by == 1, "R11 wrong address", ry_by, 1);
    rd_chk('h50, "R11 no program");
    unlock(); wr(0, 'hF0); wr('h51, 0);
    chk(ry_by == 1, "R11 F0 aborts", ry_by, 1);
    rd_chk('h51, "R11 F0 no program");
    prog('h52, 'h00FF); wait_ready(k); m['h52] &= 16'h00FF;
    rd_chk('h52, "R11 later command works");

    // R1 write pulse with output enable low
    unlock(); wr('h555, 'hA0);
    addr = 12'h53; dq_in = 0; ce_n = 0; oe_n = 0; we_n = 0;
    @(negedge clk); we_n = 1; oe_n = 1; ce_n = 1; @(negedge clk);
    chk(ry_by == 1, "R1 oe low pulse ignored", ry_by, 1);
    wr('h53, 'h0F0F); wait_ready(k); m['h53] &= 16'h0F0F;
    rd_chk('h53, "R1 sequence kept");

    // R12 byte mode
    word_mode = 0;
    prog('hC1, 'h5A); wait_ready(k); m['h60] &= 16'h5AFF;
    rd('hC1, r1); chk(r1 == 16'h005A, "R12 high byte", r1, 16'h005A);
    rd('hC0, r1); chk(r1 == 16'h00FF, "R12 low byte", r1, 16'h00FF);
    word_mode = 1;
    rd_chk('h60, "R12 word view");

    // R9 suspend and resume
    prog('h80, 0); wait_ready(k); m['h80] = 0;
    erase_sec('h80); wr(0, 'hB0); @(negedge clk);
    chk(ry_by == 1, "R9 suspended ready", ry_by, 1);
    rd_chk('h90, "R9 read outside erase");
    rd('h80, r1); rd('h80, r2);
    chk(r1[7] == 1 && r1[6] == r2[6] && r1[2] != r2[2], "R9 R8 suspend status", r2, r1 ^ 16'h0004);
    prog('h81, 0);
    chk(ry_by == 1, "R9 program to erasing sector ignored", ry_by, 1);
    prog('h90, 'h00F0);
    chk(ry_by == 0, "R9 program in suspend busy", ry_by, 0);
    wait_ready(k); m['h90] &= 16'h00F0;
    rd_chk('h90, "R9 program in suspend");
    wr(0, 'h30);
    chk(ry_by == 0, "R9 resume busy", ry_by, 0);
    wait_ready(k); model_erase(19'(1) << sec_m('h80, 0));
    rd_chk('h80, "R9 erase finished"); rd_chk('h81, "R9 erase finished 2");

    // R10 reset aborts program
    prog('h70, 0); @(negedge clk);
    rst_n = 0; @(negedge clk);
    chk(ry_by == 1, "R10 reset abort ready", ry_by, 1);
    rst_n = 1; @(negedge clk);
    rd_chk('h70, "R10 location unchanged");

    // R9 suspend on the final erase clock
    prog('hA0, 0); wait_ready(k); m['hA0] = 0;
    erase_sec('hA0);
    repeat (EC - 2) @(negedge clk);
    wr(0, 'hB0);
    chk(ry_by == 1, "R9 final-clock suspend ready", ry_by, 1);
    model_erase(19'(1) << sec_m('hA0, 0));
    rd_chk('hA0, "R9 final-clock erase complete");
    repeat (4) @(negedge clk);
    chk(ry_by == 1, "R9 stays in read mode", ry_by, 1);

    // R2 R4 random programs and erases
    for (int it = 0; it < 30; it++) begin
      int a = $urandom_range(0, 255);
      int d = $urandom_range(0, 65535);
      prog(a, d); wait_ready(k); m[a] &= 16'(d);
      rd_chk(a, "R2 random program");
      if (it % 10 == 9) begin
        erase_sec(a); wait_ready(k);
        model_erase(19'(1) << sec_m(a, 0));
        rd_chk(a, "R4 random erase");
        rd_chk($urandom_range(0, 255), "R4 random neighbour");
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule